// File: doc/BRIEF.md
# Key-Guarded Configuration Register

This block holds one configuration word that software can change only through a fixed three-write unlock ritual on a simple register bus. A write of the opening key code to the first key location arms the block. The next write, to the configuration location, places the intended value in a hidden staging register. A write of the closing key code to the second key location then copies the staged value into the live configuration, which drives the `cfg_out` pins.

The sequence is tracked by a three-state machine (idle, armed, staged). Any write that breaks the pattern returns the machine to idle and clears the staged value:

- a wrong key code;
- a write to an unrelated address;
- a key written at the wrong step.

Reads never take part in the sequence. A read of the configuration location returns the live value. A read of either key location returns zero. The interface is a single-cycle strobe bus with no wait states. Read data is combinational from the address and the read strobe.

Top module: `cfg_keylock_reg`

## Requirements
- R1: After reset, `cfg_out` is 0, a read of the configuration location (0x654) returns 0, and the sequence is idle. A sequence left unfinished when reset was asserted does not complete after reset is released.
- R2: The live value is committed by three consecutive writes with no other write between them: first 0x9A to 0x650, then the new value to 0x654, then 0x0C to 0x658. `cfg_out` shows the new value from the clock edge that accepts the 0x658 write.
- R3: A write to 0x654 while the sequence is not armed changes nothing. A later 0x0C write to 0x658 does not commit it either.
- R4: A write to 0x650 with any code other than 0x9A leaves the sequence idle. The following value and closing-key writes have no effect.
- R5: In the staged state, a write to 0x658 with any code other than 0x0C aborts the sequence and leaves `cfg_out` unchanged.
- R6: A write to any address other than the one expected next, while armed or staged, aborts the sequence and discards the staged value.
- R7: Writing the keys out of order aborts the sequence. This covers 0x658 written directly after 0x650, and 0x650 written twice in a row.
- R8: `rdata` is 0 unless `rd_en` is high and the address is 0x654, in which case it returns the live value zero-extended. Reads of 0x650 and 0x658 return 0. Reads never advance or abort the sequence.
- R9: The committed value is the low 8 bits of the value write. Higher data bits are ignored.
- R10: Key codes are compared against the whole 32-bit data word. A key write whose upper bits are not all zero counts as a wrong key.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Register offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle `rd_en` is high |
| cfg_out | output | 8 | Live committed configuration word |

## Verification
The hardest situation to reach from the ports is an abort from the staged state, because the staged value is never visible on any output. The only evidence that it was discarded is that a later closing key does not commit it. The stimulus therefore always follows each broken sequence with the rest of a would-be valid sequence: a value write and a correct closing key. It then checks that `cfg_out` still holds the value from the last good commit. Reads are interleaved inside a live sequence, and a reset is applied while a sequence is staged, to show that neither disturbs nor completes the sequence.

// File: rtl/cfg_keylock_pkg.sv
package cfg_keylock_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE   = 2'd0,
      SEQ_ARMED  = 2'd1,
      SEQ_STAGED = 2'd2
   } seq_state_e;

   // one-hot positions of the decoded address hits
   localparam int HIT_KEY0 = 0;
   localparam int HIT_CFG  = 1;
   localparam int HIT_KEY1 = 2;
   localparam int HIT_N    = 3;

endpackage

// File: rtl/ckl_addr_decode.sv
module ckl_addr_decode #(
   parameter int                ADDR_W    = 12,
   parameter logic [ADDR_W-1:0] KEY0_ADDR = 12'h650,
   parameter logic [ADDR_W-1:0] CFG_ADDR  = 12'h654,
   parameter logic [ADDR_W-1:0] KEY1_ADDR = 12'h658
) (
   input  logic [ADDR_W-1:0]                 addr,
   output logic [cfg_keylock_pkg::HIT_N-1:0] hit
);
   import cfg_keylock_pkg::*;

   if (KEY0_ADDR == CFG_ADDR || KEY0_ADDR == KEY1_ADDR || CFG_ADDR == KEY1_ADDR) begin : g_addr_clash
      $error("ckl_addr_decode: register offsets must be distinct");
   end

   always_comb begin
      hit           = '0;
      hit[HIT_KEY0] = (addr == KEY0_ADDR);
      hit[HIT_CFG]  = (addr == CFG_ADDR);
      hit[HIT_KEY1] = (addr == KEY1_ADDR);
   end

endmodule

// File: rtl/ckl_key_match.sv
module ckl_key_match #(
   parameter int               DATA_W = 32,
   parameter int               KEY_W  = 8,
   parameter logic [KEY_W-1:0] CODE   = 8'h9A,
   parameter bit               STRICT = 1'b1
) (
   input  logic [DATA_W-1:0] data,
   output logic              match
);

   if (KEY_W > DATA_W) begin : g_width_bad
      $error("ckl_key_match: KEY_W must not exceed DATA_W");
   end

   if (STRICT) begin : g_full_word
      // whole data word must equal the code, upper bits zero
      assign match = (data == DATA_W'(CODE));
   end else begin : g_low_bits
      assign match = (data[KEY_W-1:0] == CODE);
   end

endmodule

// File: rtl/ckl_seq_fsm.sv
module ckl_seq_fsm
   import cfg_keylock_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [HIT_N-1:0] hit,
   input  logic             key0_ok,
   input  logic             key1_ok,
   output seq_state_e       state,
   output logic             load_shadow,
   output logic             clear_shadow,
   output logic             commit
);

   seq_state_e state_d;

   always_comb begin
      state_d      = state;
      load_shadow  = 1'b0;
      clear_shadow = 1'b0;
      commit       = 1'b0;
      if (wr_en) begin
         unique case (state)
            SEQ_IDLE: begin
               if (hit[HIT_KEY0] && key0_ok) state_d = SEQ_ARMED;
            end
            SEQ_ARMED: begin
               if (hit[HIT_CFG]) begin
                  state_d     = SEQ_STAGED;
                  load_shadow = 1'b1;
               end else begin
                  state_d      = SEQ_IDLE;
                  clear_shadow = 1'b1;
               end
            end
            SEQ_STAGED: begin
               state_d      = SEQ_IDLE;
               clear_shadow = 1'b1;
               commit       = hit[HIT_KEY1] && key1_ok;
            end
            default: begin
               state_d      = SEQ_IDLE;
               clear_shadow = 1'b1;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= SEQ_IDLE;
      else        state <= state_d;
   end

endmodule

// File: rtl/ckl_cfg_store.sv
module ckl_cfg_store #(
   parameter int              CFG_W     = 8,
   parameter logic [CFG_W-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_shadow,
   input  logic             clear_shadow,
   input  logic             commit,
   input  logic [CFG_W-1:0] wcfg,
   output logic [CFG_W-1:0] shadow_q,
   output logic [CFG_W-1:0] active_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= '0;
      end else if (load_shadow) begin
         shadow_q <= wcfg;
      end else if (clear_shadow) begin
         shadow_q <= '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      active_q <= RESET_VAL;
      else if (commit) active_q <= shadow_q;
   end

endmodule

// File: rtl/cfg_keylock_reg.sv
module cfg_keylock_reg #(
   parameter int                ADDR_W    = 12,
   parameter int                DATA_W    = 32,
   parameter int                CFG_W     = 8,
   parameter int                KEY_W     = 8,
   parameter logic [ADDR_W-1:0] KEY0_ADDR = 12'h650,
   parameter logic [ADDR_W-1:0] CFG_ADDR  = 12'h654,
   parameter logic [ADDR_W-1:0] KEY1_ADDR = 12'h658,
   parameter logic [KEY_W-1:0]  KEY0_CODE = 8'h9A,
   parameter logic [KEY_W-1:0]  KEY1_CODE = 8'h0C,
   parameter bit                STRICT    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [CFG_W-1:0]  cfg_out
);
   import cfg_keylock_pkg::*;

   localparam int PAD_W = DATA_W - CFG_W;

   if (CFG_W < 1 || CFG_W > DATA_W) begin : g_cfg_width_bad
      $error("cfg_keylock_reg: CFG_W must be in 1..DATA_W");
   end
   if (KEY0_CODE == '0 || KEY1_CODE == '0) begin : g_key_zero
      $error("cfg_keylock_reg: key codes must differ from the reset value");
   end

   logic [HIT_N-1:0]  hit;
   logic              key0_ok, key1_ok;
   seq_state_e        state;
   logic              load_shadow, clear_shadow, commit;
   logic [CFG_W-1:0]  shadow_q, active_q;
   logic [DATA_W-1:0] cfg_word;

   ckl_addr_decode #(
      .ADDR_W(ADDR_W), .KEY0_ADDR(KEY0_ADDR), .CFG_ADDR(CFG_ADDR), .KEY1_ADDR(KEY1_ADDR)
   ) u_dec (
      .addr(addr), .hit(hit)
   );

   ckl_key_match #(.DATA_W(DATA_W), .KEY_W(KEY_W), .CODE(KEY0_CODE), .STRICT(STRICT))
      u_key0 (.data(wdata), .match(key0_ok));

   ckl_key_match #(.DATA_W(DATA_W), .KEY_W(KEY_W), .CODE(KEY1_CODE), .STRICT(STRICT))
      u_key1 (.data(wdata), .match(key1_ok));

   ckl_seq_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .hit(hit),
      .key0_ok(key0_ok), .key1_ok(key1_ok), .state(state),
      .load_shadow(load_shadow), .clear_shadow(clear_shadow), .commit(commit)
   );

   ckl_cfg_store #(.CFG_W(CFG_W)) u_store (
      .clk(clk), .rst_n(rst_n), .load_shadow(load_shadow), .clear_shadow(clear_shadow),
      .commit(commit), .wcfg(wdata[CFG_W-1:0]), .shadow_q(shadow_q), .active_q(active_q)
   );

   if (PAD_W > 0) begin : g_pad
      assign cfg_word = {{PAD_W{1'b0}}, active_q};
   end else begin : g_nopad
      assign cfg_word = active_q;
   end

   // key locations are write-only and read back as zero
   assign rdata   = (rd_en && hit[HIT_CFG]) ? cfg_word : '0;
   assign cfg_out = active_q;

endmodule

// File: rtl/cfg_keylock_chk.sv
module cfg_keylock_chk
   import cfg_keylock_pkg::*;
#(
   parameter int                ADDR_W    = 12,
   parameter int                DATA_W    = 32,
   parameter int                CFG_W     = 8,
   parameter logic [ADDR_W-1:0] KEY0_ADDR = 12'h650,
   parameter logic [ADDR_W-1:0] CFG_ADDR  = 12'h654,
   parameter logic [ADDR_W-1:0] KEY1_ADDR = 12'h658,
   parameter logic [7:0]        KEY1_CODE = 8'h0C
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic [CFG_W-1:0]  cfg_out,
   input seq_state_e        state,
   input logic [CFG_W-1:0]  shadow_q
);

   logic good_close;
   assign good_close = state == SEQ_STAGED && wr_en && addr == KEY1_ADDR
                       && wdata == DATA_W'(KEY1_CODE);

   // R2
   commit_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      good_close |=> cfg_out == $past(shadow_q));

   // R3
   hold_unless_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !good_close |=> $stable(cfg_out));

   // R6
   armed_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_ARMED && wr_en && addr != CFG_ADDR) |=> state == SEQ_IDLE);

   // R6
   idle_shadow_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state == SEQ_IDLE |-> shadow_q == '0);

   // R8
   key_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (addr == KEY0_ADDR || addr == KEY1_ADDR)) |-> rdata == '0);

   // R8
   read_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(state));

endmodule

bind cfg_keylock_reg cfg_keylock_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_W(CFG_W),
   .KEY0_ADDR(KEY0_ADDR), .CFG_ADDR(CFG_ADDR), .KEY1_ADDR(KEY1_ADDR), .KEY1_CODE(8'(KEY1_CODE))
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
   .rdata(rdata), .cfg_out(cfg_out), .state(state), .shadow_q(shadow_q)
);

// File: tb/cfg_keylock_reg_bench.sv
`timescale 1ns/1ps
module cfg_keylock_reg_bench;

   localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_OUT = 2'd2;

   typedef struct packed {
      logic [1:0]  op;
      logic [11:0] a;
      logic [31:0] d;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 62;
   localparam vec_t VEC [NV] = '{
      '{OP_OUT, 12'h000, 32'h00, 8'd1},          // R1 reset value
      '{OP_RD,  12'h654, 32'h00, 8'd1},          // R1 readback
      '{OP_WR,  12'h650, 32'h9A, 8'd2},
      '{OP_WR,  12'h654, 32'h5A, 8'd2},
      '{OP_WR,  12'h658, 32'h0C, 8'd2},
      '{OP_OUT, 12'h000, 32'h5A, 8'd2},          // R2 commit
      '{OP_RD,  12'h654, 32'h5A, 8'd8},          // R8 readback
      '{OP_WR,  12'h654, 32'h33, 8'd3},
      '{OP_WR,  12'h658, 32'h0C, 8'd3},
      '{OP_OUT, 12'h000, 32'h5A, 8'd3},          // R3 unarmed value
      '{OP_WR,  12'h650, 32'h9B, 8'd4},
      '{OP_WR,  12'h654, 32'h44, 8'd4},
      '{OP_WR,  12'h658, 32'h0C, 8'd4},
      '{OP_OUT, 12'h000, 32'h5A, 8'd4},          // R4 wrong opening key
      '{OP_WR,  12'h650, 32'h9A, 8'd5},
      '{OP_WR,  12'h654, 32'h66, 8'd5},
      '{OP_WR,  12'h658, 32'h0D, 8'd5},
      '{OP_OUT, 12'h000, 32'h5A, 8'd5},          // R5 wrong closing key
      '{OP_WR,  12'h650, 32'h9A, 8'd6},
      '{OP_WR,  12'h700, 32'h00, 8'd6},
      '{OP_WR,  12'h654, 32'h77, 8'd6},
      '{OP_WR,  12'h658, 32'h0C, 8'd6},
      '{OP_OUT, 12'h000, 32'h5A, 8'd6},          // R6 foreign write while armed
      '{OP_WR,  12'h650, 32'h9A, 8'd6},
      '{OP_WR,  12'h654, 32'h78, 8'd6},
      '{OP_WR,  12'h660, 32'h01, 8'd6},
      '{OP_WR,  12'h658, 32'h0C, 8'd6},
      '{OP_OUT, 12'h000, 32'h5A, 8'd6},          // R6 foreign write while staged
      '{OP_WR,  12'h650, 32'h9A, 8'd7},
      '{OP_WR,  12'h658, 32'h0C, 8'd7},
      '{OP_OUT, 12'h000, 32'h5A, 8'd7},          // R7 closing key too early
      '{OP_WR,  12'h654, 32'h11, 8'd7},
      '{OP_WR,  12'h658, 32'h0C, 8'd7},
      '{OP_OUT, 12'h000, 32'h5A, 8'd7},          // R7 sequence really aborted
      '{OP_WR,  12'h650, 32'h9A, 8'd7},
      '{OP_WR,  12'h650, 32'h9A, 8'd7},
      '{OP_WR,  12'h654, 32'h22, 8'd7},
      '{OP_WR,  12'h658, 32'h0C, 8'd7},
      '{OP_OUT, 12'h000, 32'h5A, 8'd7},          // R7 opening key twice
      '{OP_WR,  12'h650, 32'h9A, 8'd8},
      '{OP_RD,  12'h650, 32'h00, 8'd8},          // R8 key read zero
      '{OP_WR,  12'h654, 32'hC3, 8'd8},
      '{OP_RD,  12'h658, 32'h00, 8'd8},          // R8 key read zero
      '{OP_WR,  12'h658, 32'h0C, 8'd8},
      '{OP_OUT, 12'h000, 32'hC3, 8'd8},          // R8 reads did not break it
      '{OP_WR,  12'h650, 32'h9A, 8'd9},
      '{OP_WR,  12'h654, 32'hFFFFFF3C, 8'd9},
      '{OP_WR,  12'h658, 32'h0C, 8'd9},
      '{OP_OUT, 12'h000, 32'h3C, 8'd9},          // R9 upper bits dropped
      '{OP_RD,  12'h654, 32'h3C, 8'd9},          // R9 zero-extended read
      '{OP_WR,  12'h650, 32'h19A, 8'd10},
      '{OP_WR,  12'h654, 32'h01, 8'd10},
      '{OP_WR,  12'h658, 32'h0C, 8'd10},
      '{OP_OUT, 12'h000, 32'h3C, 8'd10},         // R10 opening key upper bits
      '{OP_WR,  12'h650, 32'h9A, 8'd10},
      '{OP_WR,  12'h654, 32'h02, 8'd10},
      '{OP_WR,  12'h658, 32'h10C, 8'd10},
      '{OP_OUT, 12'h000, 32'h3C, 8'd10},         // R10 closing key upper bits
      '{OP_WR,  12'h650, 32'h9A, 8'd2},
      '{OP_WR,  12'h654, 32'h00, 8'd2},
      '{OP_WR,  12'h658, 32'h0C, 8'd2},
      '{OP_OUT, 12'h000, 32'h00, 8'd2}           // R2 commit of zero
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [7:0]  cfg_out;
   int          checks = 0, errors = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   cfg_keylock_reg u_cfg_keylock_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .cfg_out(cfg_out)
   );

   task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; addr = '0; wdata = '0;
   endtask

   task automatic do_rd(input int req, input logic [11:0] a, input logic [31:0] exp);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      #1 check(req, rdata, exp);
      rd_en = 1'b0; addr = '0;
   endtask

   task automatic do_out(input int req, input logic [31:0] exp);
      @(negedge clk);
      #1 check(req, {24'h0, cfg_out}, exp);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         case (VEC[i].op)
            OP_WR:   do_wr(VEC[i].a, VEC[i].d);
            OP_RD:   do_rd(int'(VEC[i].req), VEC[i].a, VEC[i].d);
            default: do_out(int'(VEC[i].req), VEC[i].d);
         endcase
      end

      // R8: configuration address without read strobe reads zero
      do_wr(12'h650, 32'h9A);
      do_wr(12'h654, 32'hA5);
      do_wr(12'h658, 32'h0C);
      @(negedge clk);
      addr = 12'h654;
      #1 check(8, rdata, 32'h0);
      addr = '0;
      // R2: visible right after the accepting edge
      do_out(2, 32'hA5);

      // R1: reset in the staged state, closing key afterwards does nothing
      do_wr(12'h650, 32'h9A);
      do_wr(12'h654, 32'h99);
      @(negedge clk);
      rst_n = 1'b0;
      #1 check(1, {24'h0, cfg_out}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      do_wr(12'h658, 32'h0C);
      do_out(1, 32'h0);
      do_rd(1, 12'h654, 32'h0);

      // R2: back-to-back valid sequences
      do_wr(12'h650, 32'h9A);
      do_wr(12'h654, 32'h81);
      do_wr(12'h658, 32'h0C);
      do_wr(12'h650, 32'h9A);
      do_wr(12'h654, 32'h7E);
      do_wr(12'h658, 32'h0C);
      do_out(2, 32'h7E);

      finish_run();
   end

endmodule